// File: doc/BRIEF.md
# Multi-Mode 16-bit Waveform Timer

This block is a 16-bit up/down counter with a selectable waveform behaviour. A 4-bit mode input picks one of sixteen settings:

- free-running counting;
- clear-on-compare counting;
- single-slope (fast) PWM;
- dual-slope PWM, in a variant whose compare value updates at the peak and a variant whose compare value updates at the valley;
- one reserved setting, in which the counter freezes.

The count ceiling (TOP) comes from one of three places: a fixed 8/9/10-bit value, the active compare value, or an externally supplied capture value.

The compare value is double-buffered. A write always lands in a staging register. The mode then decides when the staged value becomes the active one: at once, when the counter arrives at TOP, or when it arrives at zero. The mode also decides which counter event raises the overflow flag.

The counter steps only on cycles with the count enable high, so an external prescaler sets the rate. Both flags stay set until software clears them through a write-one-to-clear input. One PWM pin is driven from the compare value.

Top module: `wave_timer16`

## Requirements
- R1: While `rst` is high, at the next clock edge the count, both flags and the PWM output become 0, the counting direction becomes up, and both compare registers become 0.
- R2: The count changes only at edges where `cnt_en` was high; with `cnt_en` low, count, flags and PWM keep their values (flag clears excepted).
- R3: Mode 0 counts up by one per enabled edge and wraps from 0xFFFF to 0; the overflow flag sets on the edge that leaves 0xFFFF.
- R4: Modes 4 and 12 count up and return to 0 on the edge after the count equals TOP (active compare value in mode 4, `capb_val` in mode 12); a count above TOP runs on to 0xFFFF and wraps; the overflow flag sets only on leaving 0xFFFF.
- R5: Modes 5/6/7 (TOP 0x00FF/0x01FF/0x03FF), 14 (TOP `capb_val`) and 15 (TOP active compare value) count up and wrap from TOP to 0; the overflow flag sets on that wrap; the PWM output goes to 1 when the count arrives at 0 and to 0 when it arrives at the active compare value, the clear winning if both apply.
- R6: Modes 1/2/3 (TOP 0x00FF/0x01FF/0x03FF), 8 and 10 (TOP `capb_val`), 9 and 11 (TOP active compare value) count up to TOP and then down to 0, turning at each end without repeating the end value; the overflow flag sets when the count arrives at 0 on a downward step; the PWM output goes to 0 on an upward arrival at the compare value and to 1 on a downward arrival; with TOP equal to 0 the count stays at 0.
- R7: A compare write always loads the staging register. In modes 0, 4, 12 and 13, the active compare value takes the written value at the same edge. In modes 1, 2, 3, 10 and 11, the staged value becomes active at the edge where the count arrives at TOP. In modes 5 to 9, 14 and 15, it becomes active at the edge where the count arrives at 0. A load that coincides with a write takes the previously staged value.
- R8: The match flag sets at the edge where the count arrives at the active compare value (as held before that edge), in every mode except 13.
- R9: `flag_clr` bit 0 clears the overflow flag and bit 1 clears the match flag; a flag event at the same edge wins over its clear.
- R10: In mode 13 the count, direction, flags (apart from clears) and PWM output hold their values even with `cnt_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Prescaled count enable, one step per high cycle |
| wgm_sel | input | 4 | Waveform mode select, 0 to 15 |
| cmpa_wr | input | 1 | Write strobe for the compare value |
| cmpa_wdata | input | 16 | Compare value to write |
| capb_val | input | 16 | Capture register value, used as TOP in modes 8, 10, 12 and 14 |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 match |
| count_o | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_flag | output | 1 | Sticky compare-match flag |
| pwm_o | output | 1 | PWM waveform output |

## Verification
Every result is registered, so any input applied before an edge shows at the outputs right after that one edge. This covers a count step, a flag set or clear, a PWM change and an immediate compare load. A buffered compare load becomes visible one edge after the count reaches TOP or zero, through the match and PWM behaviour that follows.

The driver applies inputs on the falling clock edge and queues the outputs the requirements predict after the next rising edge. The monitor pops and compares one queued item per cycle, one nanosecond after the rising edge. Predictions are therefore never more than one edge ahead of the design.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [2:0] {K_HOLD, K_NORMAL, K_CTC, K_FAST, K_DUAL} kind_e;
  typedef enum logic [1:0] {U_NOW, U_AT_TOP, U_AT_BOT} upd_e;
endpackage

// File: rtl/wt_mode_decode.sv
module wt_mode_decode import wt_pkg::*; #(
  parameter int W        = 16,
  parameter int LO_BITS  = 8,
  parameter int MID_BITS = 9,
  parameter int HI_BITS  = 10
) (
  input  logic [3:0]   mode,
  input  logic [W-1:0] ocr_a,
  input  logic [W-1:0] cap_b,
  output kind_e        kind,
  output upd_e         upd,
  output logic [W-1:0] top
);
  localparam int NFIX = 3;
  localparam int FIX_BITS [NFIX] = '{LO_BITS, MID_BITS, HI_BITS};
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] fixed_top [NFIX];

  genvar g;
  for (g = 0; g < NFIX; g++) begin : g_fix
    assign fixed_top[g] = W'((64'd1 << FIX_BITS[g]) - 64'd1);
  end

  always_comb begin
    kind = K_HOLD;
    upd  = U_NOW;
    top  = MAXV;
    unique case (mode)
      4'd0:  begin kind = K_NORMAL; upd = U_NOW;    top = MAXV;         end
      4'd1:  begin kind = K_DUAL;   upd = U_AT_TOP; top = fixed_top[0]; end
      4'd2:  begin kind = K_DUAL;   upd = U_AT_TOP; top = fixed_top[1]; end
      4'd3:  begin kind = K_DUAL;   upd = U_AT_TOP; top = fixed_top[2]; end
      4'd4:  begin kind = K_CTC;    upd = U_NOW;    top = ocr_a;        end
      4'd5:  begin kind = K_FAST;   upd = U_AT_BOT; top = fixed_top[0]; end
      4'd6:  begin kind = K_FAST;   upd = U_AT_BOT; top = fixed_top[1]; end
      4'd7:  begin kind = K_FAST;   upd = U_AT_BOT; top = fixed_top[2]; end
      4'd8:  begin kind = K_DUAL;   upd = U_AT_BOT; top = cap_b;        end
      4'd9:  begin kind = K_DUAL;   upd = U_AT_BOT; top = ocr_a;        end
      4'd10: begin kind = K_DUAL;   upd = U_AT_TOP; top = cap_b;        end
      4'd11: begin kind = K_DUAL;   upd = U_AT_TOP; top = ocr_a;        end
      4'd12: begin kind = K_CTC;    upd = U_NOW;    top = cap_b;        end
      4'd13: begin kind = K_HOLD;   upd = U_NOW;    top = MAXV;         end
      4'd14: begin kind = K_FAST;   upd = U_AT_BOT; top = cap_b;        end
      4'd15: begin kind = K_FAST;   upd = U_AT_BOT; top = ocr_a;        end
      default: ;
    endcase
  end
endmodule

// File: rtl/wt_counter.sv
module wt_counter import wt_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  kind_e        kind,
  input  logic [W-1:0] top,
  output logic [W-1:0] count,
  output logic [W-1:0] nxt,
  output logic         step_up,
  output logic         step_dn
);
  localparam logic [W-1:0] ONE = W'(1);

  logic dn, nxt_dn;

  always_comb begin
    nxt     = count;
    nxt_dn  = dn;
    step_up = 1'b0;
    step_dn = 1'b0;
    unique case (kind)
      K_NORMAL: begin
        nxt = count + ONE;
        step_up = 1'b1;
      end
      K_CTC, K_FAST: begin
        nxt = (count == top) ? '0 : count + ONE;
        step_up = 1'b1;
      end
      K_DUAL: begin
        if (top == '0) begin
          nxt    = '0;
          nxt_dn = 1'b0;
        end else if (!dn) begin
          if (count >= top) begin
            nxt = count - ONE; nxt_dn = 1'b1; step_dn = 1'b1;
          end else begin
            nxt = count + ONE; step_up = 1'b1;
          end
        end else begin
          if (count == '0) begin
            nxt = ONE; nxt_dn = 1'b0; step_up = 1'b1;
          end else begin
            nxt = count - ONE; step_dn = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      dn    <= 1'b0;
    end else if (tick) begin
      count <= nxt;
      dn    <= nxt_dn;
    end
  end
endmodule

// File: rtl/wt_cmp_buffer.sv
module wt_cmp_buffer import wt_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         tick,
  input  kind_e        kind,
  input  upd_e         upd,
  input  logic [W-1:0] nxt,
  input  logic [W-1:0] top,
  output logic [W-1:0] ocr_a
);
  logic [W-1:0] stage;
  logic         edge_hit;

  always_comb begin
    edge_hit = 1'b0;
    if (tick && kind != K_HOLD) begin
      unique case (upd)
        U_AT_TOP: edge_hit = (nxt == top);
        U_AT_BOT: edge_hit = (nxt == '0);
        default:  edge_hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
      ocr_a <= '0;
    end else begin
      if (wr) stage <= wdata;
      if (upd == U_NOW) ocr_a <= wr ? wdata : stage;
      else if (edge_hit) ocr_a <= stage;
    end
  end
endmodule

// File: rtl/wt_flags_pwm.sv
module wt_flags_pwm import wt_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  kind_e        kind,
  input  logic [W-1:0] count,
  input  logic [W-1:0] nxt,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic [W-1:0] top,
  input  logic [W-1:0] ocr_a,
  input  logic [1:0]   clr,
  output logic         ovf_evt,
  output logic         match_evt,
  output logic         ovf_flag,
  output logic         match_flag,
  output logic         pwm
);
  localparam logic [W-1:0] MAXV = '1;

  logic active;
  assign active = tick && (kind != K_HOLD);

  always_comb begin
    ovf_evt = 1'b0;
    if (active) begin
      unique case (kind)
        K_NORMAL, K_CTC: ovf_evt = (count == MAXV);
        K_FAST:          ovf_evt = (count == top);
        K_DUAL:          ovf_evt = step_dn && (nxt == '0);
        default:         ovf_evt = 1'b0;
      endcase
    end
  end

  assign match_evt = active && (nxt == ocr_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag   <= 1'b0;
      match_flag <= 1'b0;
      pwm        <= 1'b0;
    end else begin
      if (ovf_evt)     ovf_flag <= 1'b1;
      else if (clr[0]) ovf_flag <= 1'b0;
      if (match_evt)   match_flag <= 1'b1;
      else if (clr[1]) match_flag <= 1'b0;
      if (active) begin
        if (kind == K_FAST) begin
          if (nxt == ocr_a)   pwm <= 1'b0;
          else if (nxt == '0) pwm <= 1'b1;
        end else if (kind == K_DUAL && nxt == ocr_a) begin
          if (step_up)      pwm <= 1'b0;
          else if (step_dn) pwm <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wave_timer16.sv
module wave_timer16 import wt_pkg::*; #(
  parameter int W        = 16,
  parameter int LO_BITS  = 8,
  parameter int MID_BITS = 9,
  parameter int HI_BITS  = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic [3:0]   wgm_sel,
  input  logic         cmpa_wr,
  input  logic [W-1:0] cmpa_wdata,
  input  logic [W-1:0] capb_val,
  input  logic [1:0]   flag_clr,
  output logic [W-1:0] count_o,
  output logic         ovf_flag,
  output logic         match_flag,
  output logic         pwm_o
);
  kind_e        kind;
  upd_e         upd;
  logic [W-1:0] top, ocr_act, nxt;
  logic         step_up, step_dn, ovf_evt, match_evt;

  wt_mode_decode #(.W(W), .LO_BITS(LO_BITS), .MID_BITS(MID_BITS), .HI_BITS(HI_BITS)) u_dec (
    .mode(wgm_sel), .ocr_a(ocr_act), .cap_b(capb_val),
    .kind(kind), .upd(upd), .top(top)
  );

  wt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(cnt_en), .kind(kind), .top(top),
    .count(count_o), .nxt(nxt), .step_up(step_up), .step_dn(step_dn)
  );

  wt_cmp_buffer #(.W(W)) u_cmp (
    .clk(clk), .rst(rst), .wr(cmpa_wr), .wdata(cmpa_wdata), .tick(cnt_en),
    .kind(kind), .upd(upd), .nxt(nxt), .top(top), .ocr_a(ocr_act)
  );

  wt_flags_pwm #(.W(W)) u_out (
    .clk(clk), .rst(rst), .tick(cnt_en), .kind(kind), .count(count_o),
    .nxt(nxt), .step_up(step_up), .step_dn(step_dn), .top(top),
    .ocr_a(ocr_act), .clr(flag_clr), .ovf_evt(ovf_evt), .match_evt(match_evt),
    .ovf_flag(ovf_flag), .match_flag(match_flag), .pwm(pwm_o)
  );
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic [3:0]   wgm_sel,
  input logic [1:0]   flag_clr,
  input logic [W-1:0] count_o,
  input logic [W-1:0] ocr_act,
  input logic         ovf_evt,
  input logic         match_evt,
  input logic         ovf_flag,
  input logic         match_flag,
  input logic         pwm_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (count_o == '0 && !ovf_flag && !match_flag && !pwm_o));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count_o));

  a_r3_normal_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && wgm_sel == 4'd0) |=> (count_o == $past(count_o) + W'(1)));

  a_r4_ctc_return: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && wgm_sel == 4'd4 && count_o == ocr_act) |=> (count_o == '0));

  a_r9_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    (flag_clr[0] && !ovf_evt) |=> !ovf_flag);

  a_r9_match_clear: assert property (@(posedge clk) disable iff (rst)
    (flag_clr[1] && !match_evt) |=> !match_flag);

  a_r10_reserved_hold: assert property (@(posedge clk) disable iff (rst)
    (wgm_sel == 4'd13) |=> ($stable(count_o) && $stable(pwm_o)));
endmodule

bind wave_timer16 wt_checker #(.W(W)) u_wt_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .wgm_sel(wgm_sel), .flag_clr(flag_clr),
  .count_o(count_o), .ocr_act(ocr_act), .ovf_evt(ovf_evt), .match_evt(match_evt),
  .ovf_flag(ovf_flag), .match_flag(match_flag), .pwm_o(pwm_o)
);

// File: tb/tb_wave_timer16.sv
`timescale 1ns/1ps
module tb_wave_timer16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic [3:0]  wgm_sel = 4'd0;
  logic        cmpa_wr = 1'b0;
  logic [15:0] cmpa_wdata = '0;
  logic [15:0] capb_val = '0;
  logic [1:0]  flag_clr = '0;
  logic [15:0] count_o;
  logic        ovf_flag, match_flag, pwm_o;

  always #2 clk = ~clk;

  wave_timer16 dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wgm_sel(wgm_sel), .cmpa_wr(cmpa_wr),
    .cmpa_wdata(cmpa_wdata), .capb_val(capb_val), .flag_clr(flag_clr),
    .count_o(count_o), .ovf_flag(ovf_flag), .match_flag(match_flag), .pwm_o(pwm_o)
  );

  typedef struct {
    string       req;
    logic [15:0] c;
    logic        o, m, p;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, derived from the requirements
  logic [15:0] m_cnt, m_stage, m_ocr;
  logic        m_dn, m_ovf, m_match, m_pwm;
  logic [15:0] lfsr = 16'hACE1;

  task automatic push(input string req);
    exp_t e;
    e.req = req; e.c = m_cnt; e.o = m_ovf; e.m = m_match; e.p = m_pwm;
    q.push_back(e);
  endtask

  task automatic model_step(input logic en, input logic wr, input logic [15:0] wd,
                            input logic [1:0] clr);
    logic [15:0] top, nx, ocr_n;
    logic ndn, up, dw, act, oe, me, hit;
    int kind; // 0 hold, 1 free, 2 ctc, 3 fast, 4 dual
    int upd;  // 0 now, 1 at TOP, 2 at zero
    case (wgm_sel)
      4'd0:  begin kind = 1; upd = 0; top = 16'hFFFF; end
      4'd1:  begin kind = 4; upd = 1; top = 16'h00FF; end
      4'd2:  begin kind = 4; upd = 1; top = 16'h01FF; end
      4'd3:  begin kind = 4; upd = 1; top = 16'h03FF; end
      4'd4:  begin kind = 2; upd = 0; top = m_ocr;    end
      4'd5:  begin kind = 3; upd = 2; top = 16'h00FF; end
      4'd6:  begin kind = 3; upd = 2; top = 16'h01FF; end
      4'd7:  begin kind = 3; upd = 2; top = 16'h03FF; end
      4'd8:  begin kind = 4; upd = 2; top = capb_val; end
      4'd9:  begin kind = 4; upd = 2; top = m_ocr;    end
      4'd10: begin kind = 4; upd = 1; top = capb_val; end
      4'd11: begin kind = 4; upd = 1; top = m_ocr;    end
      4'd12: begin kind = 2; upd = 0; top = capb_val; end
      4'd14: begin kind = 3; upd = 2; top = capb_val; end
      4'd15: begin kind = 3; upd = 2; top = m_ocr;    end
      default: begin kind = 0; upd = 0; top = 16'hFFFF; end
    endcase
    nx = m_cnt; ndn = m_dn; up = 0; dw = 0;
    if (kind == 1) nx = m_cnt + 16'd1;
    else if (kind == 2 || kind == 3) nx = (m_cnt == top) ? 16'd0 : m_cnt + 16'd1;
    else if (kind == 4) begin
      if (top == 0) begin nx = 0; ndn = 0; end
      else if (!m_dn && m_cnt < top) begin nx = m_cnt + 16'd1; up = 1; end
      else if (!m_dn) begin nx = m_cnt - 16'd1; ndn = 1; dw = 1; end
      else if (m_cnt == 0) begin nx = 16'd1; ndn = 0; up = 1; end
      else begin nx = m_cnt - 16'd1; dw = 1; end
    end
    act = en && kind != 0;
    oe = act && (((kind == 1 || kind == 2) && m_cnt == 16'hFFFF) ||
                 (kind == 3 && m_cnt == top) || (kind == 4 && dw && nx == 0));
    me = act && nx == m_ocr;
    if (act && kind == 3) begin
      if (nx == m_ocr) m_pwm = 0; else if (nx == 0) m_pwm = 1;
    end else if (act && kind == 4 && nx == m_ocr) begin
      if (up) m_pwm = 0; else if (dw) m_pwm = 1;
    end
    hit = act && ((upd == 1 && nx == top) || (upd == 2 && nx == 0));
    ocr_n = m_ocr;
    if (upd == 0) ocr_n = wr ? wd : m_stage;
    else if (hit) ocr_n = m_stage;
    if (wr) m_stage = wd;
    m_ocr = ocr_n;
    if (en) begin m_cnt = nx; m_dn = ndn; end
    if (oe) m_ovf = 1; else if (clr[0]) m_ovf = 0;
    if (me) m_match = 1; else if (clr[1]) m_match = 0;
  endtask

  task automatic cyc(input logic en, input logic wr, input logic [15:0] wd,
                     input logic [1:0] clr, input string req);
    @(negedge clk);
    rst = 0; cnt_en = en; cmpa_wr = wr; cmpa_wdata = wd; flag_clr = clr;
    model_step(en, wr, wd, clr);
    push(req);
  endtask

  task automatic do_reset(input logic [3:0] mode);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      rst = 1; cnt_en = 0; cmpa_wr = 0; flag_clr = 0; wgm_sel = mode;
      m_cnt = 0; m_stage = 0; m_ocr = 0; m_dn = 0; m_ovf = 0; m_match = 0; m_pwm = 0;
      push("R1");
    end
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 16'd0, 2'b00, req);
  endtask

  task automatic set_mode(input logic [3:0] mode);
    @(negedge clk);
    wgm_sel = mode; cnt_en = 0; cmpa_wr = 0; flag_clr = 0;
    model_step(1'b0, 1'b0, 16'd0, 2'b00);
    push("R10");
  endtask

  // monitor: one queued prediction per rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (count_o !== e.c || ovf_flag !== e.o || match_flag !== e.m || pwm_o !== e.p) begin
          errors++;
          $display("FAIL %s: actual cnt=%h ovf=%b match=%b pwm=%b expected cnt=%h ovf=%b match=%b pwm=%b",
                   e.req, count_o, ovf_flag, match_flag, pwm_o, e.c, e.o, e.m, e.p);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset(4'd0);
    // R3 free run through 0xFFFF, R7 immediate load, R8 match
    cyc(1'b1, 1'b1, 16'd5, 2'b00, "R7");
    run(20, "R8");
    cyc(1'b1, 1'b0, 16'd0, 2'b10, "R9");
    run(65530, "R3");
    cyc(1'b0, 1'b0, 16'd0, 2'b01, "R9");
    run(5, "R3");

    // R4 mode 4, TOP from compare value, with immediate rewrite
    do_reset(4'd4);
    cyc(1'b1, 1'b1, 16'd20, 2'b00, "R7");
    run(60, "R4");
    cyc(1'b1, 1'b1, 16'd10, 2'b00, "R7");
    run(40, "R4");
    // R2 gapped enable
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], 1'b0, 16'd0, {lfsr[3], lfsr[5]}, "R2");
    end

    // R4 mode 12, TOP from capture value
    do_reset(4'd12);
    capb_val = 16'd30;
    cyc(1'b1, 1'b1, 16'd7, 2'b00, "R7");
    run(100, "R4");

    // R5 fast PWM fixed tops with buffered rewrite mid period
    for (int md = 5; md <= 7; md++) begin
      do_reset(4'(md));
      cyc(1'b1, 1'b1, 16'd100, 2'b00, "R7");
      run(300, "R5");
      cyc(1'b1, 1'b1, 16'd60, 2'b00, "R7");
      run((1 << (md + 3)) * 2, "R5");
    end

    // R10 reserved mode holds, then resume fast PWM
    set_mode(4'd13);
    cyc(1'b1, 1'b1, 16'd40, 2'b00, "R10");
    run(50, "R10");
    set_mode(4'd5);
    run(600, "R5");

    // R5 mode 14 and 15, R9 set wins over clear
    do_reset(4'd14);
    capb_val = 16'd40;
    cyc(1'b1, 1'b1, 16'd15, 2'b00, "R7");
    run(100, "R5");
    for (int i = 0; i < 100; i++) cyc(1'b1, 1'b0, 16'd0, 2'b11, "R9");
    do_reset(4'd15);
    cyc(1'b1, 1'b1, 16'd25, 2'b00, "R7");
    run(30, "R5");
    cyc(1'b1, 1'b1, 16'd12, 2'b00, "R7");
    run(80, "R5");

    // R6 dual slope fixed tops, update at TOP
    for (int md = 1; md <= 3; md++) begin
      do_reset(4'(md));
      cyc(1'b1, 1'b1, 16'd90, 2'b00, "R7");
      run(150, "R6");
      cyc(1'b1, 1'b1, 16'd200, 2'b00, "R7");
      run((1 << (md + 8)) * 2, "R6");
    end

    // R6 dual slope register tops: 8,10 from capture, 9,11 from compare
    for (int md = 8; md <= 11; md++) begin
      do_reset(4'(md));
      capb_val = 16'd50;
      cyc(1'b1, 1'b1, 16'd45, 2'b00, "R7");
      run(70, "R6");
      cyc(1'b1, 1'b1, 16'd20, 2'b00, "R7");
      run(260, "R6");
      cyc(1'b1, 1'b0, 16'd0, 2'b11, "R9");
      run(20, "R6");
    end

    // R6 TOP of zero keeps the count at 0
    do_reset(4'd8);
    capb_val = 16'd0;
    cyc(1'b1, 1'b1, 16'd9, 2'b00, "R7");
    run(10, "R6");

    cyc(1'b0, 1'b0, 16'd0, 2'b00, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule